// File: doc/BRIEF.md
# Drive Status Packet Formatter

This block assembles the ten-nibble status packet that a disc-drive controller returns to its host processor. It also decodes the matching ten-nibble command packet that the host sends. When the export strobe is seen, the block latches the drive state, the sub-status code, the minute, second and frame position values and an extension nibble into a bank of nibble registers. It stores a checksum nibble beside them. If the level-4 interrupt is enabled, it raises a one-cycle interrupt pulse.

When the command strobe is seen, the block reads the command code. For a table-of-contents query it updates the sub-status code from the query-type field. It also emits a one-cycle one-hot action request. Mechanical actions such as seek, play and tray movement are carried out elsewhere; this block only names them. A control byte sits beside the packet. An export keeps only its two low bits.

Top module: `drive_status_fmt`

## Requirements
- R1: After reset, data nibbles 0 to 8 of `stat_pkt` are zero, nibble 9 and `csum` read 0xF, `ctrl_q` is 0, and `irq_pulse` and `act_req` are low.
- R2: The checksum equals 15 minus the sum of the nine data nibbles modulo 16. It appears on `csum` and in nibble 9 (bits 39:36) in the same cycle as the data nibbles it covers.
- R3: Nibble i of `stat_pkt` occupies bits 4i+3:4i. The edge that samples `export_stb` loads: nibble 0 = `drv_state`, nibble 1 = the sub-status code, nibbles 2/3 = `minute` high/low, nibbles 4/5 = `second` high/low, nibbles 6/7 = `frame` high/low, nibble 8 = `ext_nib`. Without an export the packet holds its value.
- R4: `irq_pulse` is high for exactly the one cycle after an export, and only if `int_mask` bit 4 was set at that export.
- R5: A control write loads the full byte into `ctrl_q`. An export clears bits 7:2 of `ctrl_q` and keeps bits 1:0. When both happen in the same cycle, the written byte is masked the same way.
- R6: The command code is `cmd_pkt` bits 3:0 and the query type is bits 15:12. For code 2, a query type of 0 to 5 becomes the sub-status code; a larger query type sets it to 0xF. Every other code leaves the sub-status code unchanged. The new code appears in nibble 1 from the next export on.
- R7: `act_req` is high for the single cycle after `cmd_stb`, with exactly one bit set: bit 0 status, 1 stop, 2 query, 3 read, 4 seek, 5 pause, 6 resume, 7 fast forward, 8 rewind, 9 recover, 10 close tray, 11 open tray. Codes map 0→0, 1→1, 2→2, 3→3, 4→4, 6→5, 7→6, 8→7, 9→8, 0xA→9, 0xC→10, 0xD→11. A code-2 query with a type above 5 requests bit 0.
- R8: Codes 5, 0xB, 0xE and 0xF request bit 12, the default handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| export_stb | input | 1 | Latch a new status packet |
| drv_state | input | 4 | Drive state code, packet nibble 0 |
| minute | input | 8 | Position minute, two nibbles |
| second | input | 8 | Position second, two nibbles |
| frame | input | 8 | Position frame, two nibbles |
| ext_nib | input | 4 | Extension nibble, packet nibble 8 |
| int_mask | input | 8 | Interrupt enables; bit 4 gates the status interrupt |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| cmd_stb | input | 1 | Decode `cmd_pkt` this cycle |
| cmd_pkt | input | 40 | Command packet, nibble i at bits 4i+3:4i |
| stat_pkt | output | 40 | Status packet, checksum in bits 39:36 |
| csum | output | 4 | Checksum nibble |
| ctrl_q | output | 8 | Control byte |
| irq_pulse | output | 1 | One-cycle level-4 interrupt request |
| act_req | output | 13 | One-hot action request pulse |

## Verification
The bench aims at query types just inside and just outside the valid range (5 and 6, plus 0xF). A decoder with an off-by-one bound would report a wrong sub-status or ask for a query instead of a status. It steps through every unassigned command code, which a decoder with a missing case would map to a real action. It exports with the interrupt mask bit clear and then set, which catches an ungated or stretched pulse. It also checks that non-query commands leave the sub-status alone, and that an export strips the upper control bits even when a write lands in the same cycle.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int NIB_W     = 4;
  localparam int N_DATA    = 9;
  localparam int N_NIB     = N_DATA + 1;
  localparam int PKT_W     = N_NIB * NIB_W;
  localparam int DATA_W    = N_DATA * NIB_W;
  localparam int MAX_QUERY = 5;
  localparam int IRQ_BIT   = 4;
  localparam int CTRL_W    = 8;
  localparam int CTRL_KEEP = 2;
  localparam int N_ACT     = 13;
  localparam logic [NIB_W-1:0] QUERY_CODE = 4'h2;

  typedef enum logic [3:0] {
    ACT_STATUS  = 4'd0,
    ACT_STOP    = 4'd1,
    ACT_QUERY   = 4'd2,
    ACT_READ    = 4'd3,
    ACT_SEEK    = 4'd4,
    ACT_PAUSE   = 4'd5,
    ACT_RESUME  = 4'd6,
    ACT_FFWD    = 4'd7,
    ACT_REWIND  = 4'd8,
    ACT_RECOVER = 4'd9,
    ACT_CLOSE   = 4'd10,
    ACT_OPEN    = 4'd11,
    ACT_OTHER   = 4'd12
  } act_e;

  // inverted low nibble of the sum of all data nibbles
  function automatic logic [NIB_W-1:0] pkt_csum(input logic [DATA_W-1:0] d);
    logic [NIB_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_DATA; i++) acc = acc + d[i*NIB_W +: NIB_W];
    return ~acc;
  endfunction

  function automatic act_e decode_act(input logic [NIB_W-1:0] code, input logic query_ok);
    case (code)
      4'h0: return ACT_STATUS;
      4'h1: return ACT_STOP;
      4'h2: return query_ok ? ACT_QUERY : ACT_STATUS;
      4'h3: return ACT_READ;
      4'h4: return ACT_SEEK;
      4'h6: return ACT_PAUSE;
      4'h7: return ACT_RESUME;
      4'h8: return ACT_FFWD;
      4'h9: return ACT_REWIND;
      4'hA: return ACT_RECOVER;
      4'hC: return ACT_CLOSE;
      4'hD: return ACT_OPEN;
      default: return ACT_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/dsp_cmd_decode.sv
module dsp_cmd_decode
  import dsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_stb,
  input  logic [PKT_W-1:0]     cmd_pkt,
  output logic [NIB_W-1:0]     sub_status,
  output logic [N_ACT-1:0]     act_req
);
  logic [NIB_W-1:0] code_w;
  logic [NIB_W-1:0] qtype_w;
  logic             query_ok_w;
  logic             query_hit_w;
  act_e             act_sel_w;

  assign code_w      = cmd_pkt[0 +: NIB_W];
  assign qtype_w     = cmd_pkt[3*NIB_W +: NIB_W];
  assign query_ok_w  = (qtype_w <= NIB_W'(MAX_QUERY));
  assign query_hit_w = cmd_stb && (code_w == QUERY_CODE);
  assign act_sel_w   = decode_act(code_w, query_ok_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_status <= '0;
      act_req    <= '0;
    end else begin
      act_req <= cmd_stb ? (N_ACT'(1) << act_sel_w) : '0;
      if (query_hit_w) sub_status <= query_ok_w ? qtype_w : '1;
    end
  end
endmodule

// File: rtl/dsp_pkt_build.sv
module dsp_pkt_build
  import dsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 export_stb,
  input  logic [DATA_W-1:0]    data_in,
  input  logic                 irq_en,
  output logic [PKT_W-1:0]     stat_pkt,
  output logic [NIB_W-1:0]     csum,
  output logic                 irq_pulse
);
  logic [DATA_W-1:0] data_q;
  logic [NIB_W-1:0]  csum_q;
  logic [NIB_W-1:0]  csum_next_w;

  assign csum_next_w = pkt_csum(data_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      csum_q    <= '1;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= export_stb && irq_en;
      if (export_stb) begin
        data_q <= data_in;
        csum_q <= csum_next_w;
      end
    end
  end

  assign stat_pkt = {csum_q, data_q};
  assign csum     = csum_q;
endmodule

// File: rtl/dsp_ctrl_reg.sv
module dsp_ctrl_reg
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              trim,
  output logic [CTRL_W-1:0] q
);
  localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'((1 << CTRL_KEEP) - 1);
  logic [CTRL_W-1:0] base_w;

  assign base_w = wr ? wdata : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= trim ? (base_w & KEEP_MASK) : base_w;
  end
endmodule

// File: rtl/drive_status_fmt.sv
module drive_status_fmt
  import dsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              export_stb,
  input  logic [3:0]        drv_state,
  input  logic [7:0]        minute,
  input  logic [7:0]        second,
  input  logic [7:0]        frame,
  input  logic [3:0]        ext_nib,
  input  logic [7:0]        int_mask,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  input  logic              cmd_stb,
  input  logic [39:0]       cmd_pkt,
  output logic [39:0]       stat_pkt,
  output logic [3:0]        csum,
  output logic [7:0]        ctrl_q,
  output logic              irq_pulse,
  output logic [12:0]       act_req
);
  logic [NIB_W-1:0]  sub_status_w;
  logic [DATA_W-1:0] data_w;

  // nibble 0 at the least significant end
  assign data_w = {ext_nib,
                   frame[3:0],  frame[7:4],
                   second[3:0], second[7:4],
                   minute[3:0], minute[7:4],
                   sub_status_w, drv_state};

  dsp_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .cmd_pkt    (cmd_pkt),
    .sub_status (sub_status_w),
    .act_req    (act_req)
  );

  dsp_pkt_build u_pkt (
    .clk        (clk),
    .rst_n      (rst_n),
    .export_stb (export_stb),
    .data_in    (data_w),
    .irq_en     (int_mask[IRQ_BIT]),
    .stat_pkt   (stat_pkt),
    .csum       (csum),
    .irq_pulse  (irq_pulse)
  );

  dsp_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .wdata (ctrl_wdata),
    .trim  (export_stb),
    .q     (ctrl_q)
  );
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker
  import dsp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        export_stb,
  input logic [7:0]  int_mask,
  input logic        cmd_stb,
  input logic [39:0] stat_pkt,
  input logic [3:0]  csum,
  input logic [7:0]  ctrl_q,
  input logic        irq_pulse,
  input logic [12:0] act_req
);
  logic [7:0] nib_sum;
  always_comb begin
    nib_sum = '0;
    for (int i = 0; i < N_DATA; i++) nib_sum = nib_sum + 8'(stat_pkt[i*NIB_W +: NIB_W]);
  end

  AST_CSUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    csum == 4'(4'hF - nib_sum[3:0])); // R2
  AST_CSUM_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pkt[39:36] == csum); // R2
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !export_stb |=> $stable(stat_pkt)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(export_stb && int_mask[IRQ_BIT])); // R4
  AST_CTRL_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    export_stb |=> ctrl_q[7:2] == 6'd0); // R5
  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_req)); // R7
  AST_ACT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req != 13'd0) |-> $past(cmd_stb)); // R7
  AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> $countones(act_req) == 1); // R7
endmodule

bind drive_status_fmt dsp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .export_stb (export_stb),
  .int_mask   (int_mask),
  .cmd_stb    (cmd_stb),
  .stat_pkt   (stat_pkt),
  .csum       (csum),
  .ctrl_q     (ctrl_q),
  .irq_pulse  (irq_pulse),
  .act_req    (act_req)
);

// File: tb/tb_drive_status_fmt.sv
module tb_drive_status_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        export_stb = 1'b0;
  logic [3:0]  drv_state = '0;
  logic [7:0]  minute = '0, second = '0, frame = '0;
  logic [3:0]  ext_nib = '0;
  logic [7:0]  int_mask = '0;
  logic        ctrl_wr = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic        cmd_stb = 1'b0;
  logic [39:0] cmd_pkt = '0;
  logic [39:0] stat_pkt;
  logic [3:0]  csum;
  logic [7:0]  ctrl_q;
  logic        irq_pulse;
  logic [12:0] act_req;

  int total = 0;
  int fails = 0;
  logic [3:0] model_sub = 4'h0;

  always #4 clk = ~clk;

  drive_status_fmt dut (.*);

  // export vectors: {state, minute, second, frame, ext}
  localparam logic [31:0] EXP_VEC [4] = '{
    32'h1_12_34_56_7, 32'hF_FF_FF_FF_F, 32'h0_00_00_01_0, 32'h9_59_59_74_3};
  // command vectors: {code, query type, expected action bit, unused}
  localparam logic [15:0] CMD_VEC [20] = '{
    16'h0000, 16'h1010, 16'h2020, 16'h2320, 16'h2520, 16'h2600, 16'h2F00,
    16'h3030, 16'h4940, 16'h50C0, 16'h6050, 16'h7060, 16'h8070, 16'h9080,
    16'hA090, 16'hB0C0, 16'hC0A0, 16'hD0B0, 16'hE0C0, 16'hF2C0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_pkt(input logic [3:0] st, input logic [3:0] sb,
      input logic [7:0] m, input logic [7:0] s, input logic [7:0] f, input logic [3:0] e);
    int sum;
    logic [3:0] n [9];
    logic [39:0] p;
    n[0] = st; n[1] = sb; n[2] = m[7:4]; n[3] = m[3:0];
    n[4] = s[7:4]; n[5] = s[3:0]; n[6] = f[7:4]; n[7] = f[3:0]; n[8] = e;
    sum = 0;
    p = '0;
    for (int i = 0; i < 9; i++) begin
      sum += int'(n[i]);
      p[i*4 +: 4] = n[i];
    end
    p[39:36] = 4'(15 - (sum % 16));
    return p;
  endfunction

  task automatic do_export(input logic [31:0] v, input logic mask4);
    logic [39:0] e;
    @(negedge clk);
    {drv_state, minute, second, frame, ext_nib} = v;
    int_mask = mask4 ? 8'h10 : 8'hEF;
    export_stb = 1'b1;
    @(negedge clk);
    export_stb = 1'b0;
    e = exp_pkt(v[31:28], model_sub, v[27:20], v[19:12], v[11:4], v[3:0]);
    chk(stat_pkt == e, "R3 packet", 64'(stat_pkt), 64'(e));
    chk(csum == e[39:36], "R2 checksum", 64'(csum), 64'(e[39:36]));
    chk(irq_pulse == mask4, "R4 irq", 64'(irq_pulse), 64'(mask4));
    @(negedge clk);
    chk(irq_pulse == 1'b0, "R4 irq width", 64'(irq_pulse), 64'd0);
    chk(stat_pkt == e, "R3 hold", 64'(stat_pkt), 64'(e));
  endtask

  initial begin
    #1_000_000;
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stat_pkt == 40'hF_0000_0000_0, "R1 packet", 64'(stat_pkt), 64'hF000000000);
    chk(csum == 4'hF, "R1 checksum", 64'(csum), 64'hF);
    chk(ctrl_q == 8'h00, "R1 ctrl", 64'(ctrl_q), 64'h0);
    chk(irq_pulse == 1'b0 && act_req == 13'd0, "R1 pulses", 64'({irq_pulse, act_req}), 64'd0);

    for (int i = 0; i < 4; i++) do_export(EXP_VEC[i], i[0]);

    for (int i = 0; i < 20; i++) begin
      logic [3:0] code, qt;
      logic [12:0] want;
      code = CMD_VEC[i][15:12];
      qt   = CMD_VEC[i][11:8];
      want = 13'(1) << CMD_VEC[i][7:4];
      @(negedge clk);
      cmd_pkt = {24'h0, qt, 8'h00, code};
      cmd_stb = 1'b1;
      @(negedge clk);
      cmd_stb = 1'b0;
      if (code == 4'h5 || code == 4'hB || code == 4'hE || code == 4'hF)
        chk(act_req == want, "R8 default code", 64'(act_req), 64'(want));
      else
        chk(act_req == want, "R7 action", 64'(act_req), 64'(want));
      @(negedge clk);
      chk(act_req == 13'd0, "R7 pulse width", 64'(act_req), 64'd0);
      if (code == 4'h2) model_sub = (qt <= 4'd5) ? qt : 4'hF;
      // R6 sub-status seen through nibble 1 on the next export
      @(negedge clk);
      drv_state = 4'hA;
      export_stb = 1'b1;
      @(negedge clk);
      export_stb = 1'b0;
      chk(stat_pkt[7:0] == {model_sub, 4'hA}, "R6 sub-status", 64'(stat_pkt[7:0]), 64'({model_sub, 4'hA}));
    end

    // R5 control byte
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = 8'hFF;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk(ctrl_q == 8'hFF, "R5 write", 64'(ctrl_q), 64'hFF);
    export_stb = 1'b1;
    @(negedge clk);
    export_stb = 1'b0;
    chk(ctrl_q == 8'h03, "R5 trim", 64'(ctrl_q), 64'h03);
    ctrl_wr = 1'b1; ctrl_wdata = 8'hFE; export_stb = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0; export_stb = 1'b0;
    chk(ctrl_q == 8'h02, "R5 write with export", 64'(ctrl_q), 64'h02);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule